// File: doc/BRIEF.md
# Strobe-Qualified Bus Capture

This block takes a parallel data word that arrives together with a strobe from a source that shares no clock with the system. It delivers that word into the system clock domain. Only the strobe passes through a synchronizer. A leading-edge detector on the synchronized strobe produces a single-cycle load enable, and that enable loads every bit of the bus at once into a holding register. Because of this, the bus bits need no synchronizers of their own. The captured word appears on the output together with a one-cycle valid pulse.

The output follows a valid/ready style but has no ready input. The block cannot apply back-pressure. The consumer must take the word in the cycle where `out_valid` is high. The word stays in the holding register until the next capture, so a consumer may also read it later.

Two front ends are available through a parameter:
- The level front end feeds the strobe straight into the synchronizer. Each strobe high time must then be at least one system clock period.
- The catch front end adds a flop clocked by the strobe itself. Its data input is tied high. The synchronized level clears it asynchronously, so a strobe pulse shorter than a clock period is still seen.

Top module: `strobe_bus_capture`

## Requirements
- R1: With two synchronizer stages, the bus is sampled at the third rising system clock edge after the strobe's rising edge. `out_data` and `out_valid` change on that same edge.
- R2: Each rising edge of the strobe produces exactly one capture, however long the strobe then stays high.
- R3: The internal load enable is high for one cycle only, on a 0-to-1 change of the synchronized strobe, found by comparing it with its value one cycle earlier.
- R4: `out_valid` is high for exactly one cycle per capture, in the cycle right after the holding register loads.
- R5: Between captures, `out_data` keeps the last captured word. Changes on `ext_bus` outside the capture window have no effect on it.
- R6: All `DATA_W` bits are captured together from one sample of `ext_bus`, so every bus value appears unchanged at the output.
- R7: With `FRONT_END` set to the catch mode, a strobe pulse shorter than one system clock period is captured with the same latency as in R1. Strobe rising edges must be at least six clock periods apart.
- R8: A synchronous `rst` clears `out_data` to zero and `out_valid` to low. It also clears the synchronizer, the edge detector and the catch flop, so a strobe that was in flight when reset came never produces a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; also clears the catch flop asynchronously |
| ext_stb | input | 1 | Strobe from the unrelated source; its rising edge qualifies the bus |
| ext_bus | input | DATA_W | Data word from the unrelated source |
| out_valid | output | 1 | One-cycle pulse marking a freshly captured word |
| out_data | output | DATA_W | Holding register contents |

## Verification
The assertions assume the following about the inputs:
- The bus holds steady from the strobe's rising edge through the third system clock edge after it.
- In the level mode, each strobe stays high for at least one clock period.
- Strobes arrive far enough apart that the synchronized level has returned low before the next rising edge.
- The strobe is low when reset is released.

The stimulus keeps within these limits in the following ways:
- Strobe and bus are driven on the falling clock edge.
- The bus is changed only once the capture edge has passed.
- Wide strobes are held between one and seven cycles.
- Narrow strobes are one nanosecond long and spaced ten cycles apart.
- The strobe is always dropped while reset is still asserted.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // Front-end selection for the strobe path
  typedef enum logic [0:0] {
    FE_LEVEL = 1'b0,  // strobe level goes straight into the synchronizer
    FE_CATCH = 1'b1   // strobe-clocked catch flop stretches narrow pulses
  } fe_mode_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sbc_catch.sv
module sbc_catch (
  input  logic stb,
  input  logic clr,
  output logic caught
);
  // Set by the strobe's rising edge, cleared once the system domain has seen it
  always_ff @(posedge stb or posedge clr) begin
    if (clr) caught <= 1'b0;
    else     caught <= 1'b1;
  end
endmodule

// File: rtl/sbc_edge.sv
module sbc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_prev;

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl;
  end

  assign rise = lvl & ~lvl_prev;
endmodule

// File: rtl/sbc_hold.sv
module sbc_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/strobe_bus_capture.sv
module strobe_bus_capture #(
  parameter int unsigned      DATA_W      = 8,
  parameter int unsigned      SYNC_STAGES = sbc_pkg::MIN_SYNC_STAGES,
  parameter sbc_pkg::fe_mode_e FRONT_END  = sbc_pkg::FE_LEVEL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_stb,
  input  logic [DATA_W-1:0] ext_bus,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < sbc_pkg::MIN_SYNC_STAGES) ? sbc_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

  logic front_lvl;
  logic sync_lvl;
  logic load_en;

  generate
    if (FRONT_END == sbc_pkg::FE_CATCH) begin : g_catch
      logic catch_clr;
      assign catch_clr = rst | sync_lvl;
      sbc_catch u_catch (
        .stb    (ext_stb),
        .clr    (catch_clr),
        .caught (front_lvl)
      );
    end else begin : g_level
      assign front_lvl = ext_stb;
    end
  endgenerate

  sbc_sync #(.STAGES(STAGES_USED)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (front_lvl),
    .sync_out (sync_lvl)
  );

  sbc_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sync_lvl),
    .rise (load_en)
  );

  sbc_hold #(.W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (load_en),
    .din  (ext_bus),
    .dout (out_data),
    .vld  (out_valid)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_lvl,
  input logic              load_en,
  input logic              valid,
  input logic [DATA_W-1:0] data
);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid && data == '0));

  // R3
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !load_en);

  // R4
  valid_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> valid);

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(data));

  // R3
  valid_from_rise_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($past(sync_lvl) && !$past(sync_lvl, 2)));
endmodule

bind strobe_bus_capture sbc_checker #(.DATA_W(DATA_W)) u_sbc_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_lvl (sync_lvl),
  .load_en  (load_en),
  .valid    (out_valid),
  .data     (out_data)
);

// File: tb/strobe_bus_capture_bench.sv
module strobe_bus_capture_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stb_w = 1'b0;
  logic         stb_n = 1'b0;
  logic [W-1:0] bus = '0;
  logic         vld_w, vld_n;
  logic [W-1:0] dat_w, dat_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  strobe_bus_capture #(.DATA_W(W), .FRONT_END(sbc_pkg::FE_LEVEL)) u_strobe_bus_capture (
    .clk(clk), .rst(rst), .ext_stb(stb_w), .ext_bus(bus),
    .out_valid(vld_w), .out_data(dat_w)
  );

  strobe_bus_capture #(.DATA_W(W), .FRONT_END(sbc_pkg::FE_CATCH)) u_strobe_bus_capture_narrow (
    .clk(clk), .rst(rst), .ext_stb(stb_n), .ext_bus(bus),
    .out_valid(vld_n), .out_data(dat_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One capture: wide strobe held hold_cyc cycles, narrow strobe 1 ns long.
  task automatic capture(input logic [W-1:0] v, input int hold_cyc);
    int cnt_w = 0, cnt_n = 0, at_w = 0, at_n = 0;
    logic [W-1:0] got_w = '0, got_n = '0;
    @(negedge clk);
    bus = v; stb_w = 1'b1; stb_n = 1'b1;
    #1 stb_n = 1'b0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (vld_w) begin cnt_w++; if (at_w == 0) begin at_w = n; got_w = dat_w; end end
      if (vld_n) begin cnt_n++; if (at_n == 0) begin at_n = n; got_n = dat_n; end end
      if (n == hold_cyc) stb_w = 1'b0;
      if (n == 3) bus = ~v;  // after the capture edge: must be ignored
    end
    check("R2", "wide captures per strobe", cnt_w, 1);
    check("R4", "wide valid cycles", cnt_w, 1);
    check("R1", "wide capture latency", at_w, 3);
    check("R6", "wide captured word", int'(got_w), int'(v));
    check("R5", "wide word held", int'(dat_w), int'(v));
    check("R7", "narrow captures per strobe", cnt_n, 1);
    check("R7", "narrow capture latency", at_n, 3);
    check("R7", "narrow captured word", int'(got_n), int'(v));
    check("R5", "narrow word held", int'(dat_n), int'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "wide valid in reset", int'(vld_w), 0);
    check("R8", "wide data in reset", int'(dat_w), 0);
    check("R8", "narrow valid in reset", int'(vld_n), 0);
    check("R8", "narrow data in reset", int'(dat_n), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Sweep every bus value with strobe widths 1..7 cycles
    for (int v = 0; v < (1 << W); v++) begin
      capture(W'(v), (v % 7) + 1);
    end

    // R8: reset while a strobe is in flight
    begin
      int seen = 0;
      @(negedge clk);
      bus = 4'h9; stb_w = 1'b1; stb_n = 1'b1;
      #1 stb_n = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      stb_w = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int n = 0; n < 8; n++) begin
        @(negedge clk);
        if (vld_w || vld_n) seen++;
      end
      check("R8", "captures after mid-flight reset", seen, 0);
      check("R8", "wide data after reset", int'(dat_w), 0);
      check("R8", "narrow data after reset", int'(dat_n), 0);
    end

    // Capture still works after the reset
    capture(4'hA, 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule